// File: doc/BRIEF.md
# Clock Source and Power-Management Controller

This block decides how a microcontroller core is clocked. It drives the select lines of an external clock multiplexer and multiplier. The crystal can be used at its own rate or multiplied by two or four, and a slow rate runs the core once every 1024 base cycles. An internal ring oscillator is chosen while the crystal restarts after stop mode. The block also emits a one-cycle clock-enable pulse that sets the effective core rate. The multiplexing cells, the multiplier and the oscillators themselves sit outside.

Software writes a control word that holds the rate, the automatic-return enable and a sleep request, plus a second word that holds the multiplier settle count. A change between the three multiplied rates waits until the multiplier reports lock for the programmed number of cycles. When the automatic-return enable is set, serial or interrupt activity during the slow rate brings the core back to full speed with no software action. Idle stops the core but keeps the time base running. Stop shuts the crystal down. A wake event from stop restarts the core at once on the ring oscillator. The block returns to the crystal only after the crystal has reported ready for a fixed number of consecutive cycles.

Top module: `cpm_top`

## Requirements
- R1: After reset, status reads 0x00 (rate 1x, automatic return off, run state, nothing pending), mult_sel=00, div_sel=0, src_ring=0 and xtal_en=1.
- R2: A control write (cfg_addr=0) selects the rate in bits [1:0] (00=1x, 01=2x, 10=4x, 11=slow). A change between 1x, 2x and 4x stays pending (status bit 5 set, old rate kept) until pll_lock has been high for the settle count. The settle count is written with cfg_addr=1, and its reset value is 16. mult_sel then shows the new rate.
- R3: A request for 2x or 4x while the rate is slow is refused, and status bits [1:0] remain 11. A request for 1x or slow is applied on the next clock edge.
- R4: At the slow rate, tick_en is a one-cycle pulse every 1024 cycles. The divider restarts on every rate change, so the first pulse comes 1024 cycles after the change.
- R5: At 1x, 2x or 4x outside stop, tick_en is high every cycle.
- R6: With the automatic-return bit (control bit 2) set and the rate slow, a cycle with ser_act or irq_act high sets the rate to 1x on the next edge. With the bit clear, the rate stays slow.
- R7: A control write with bits [4:3]=01 enters idle (status bits [4:3]=01). In idle core_en is low while tick_en continues. ser_act or irq_act returns the block to run.
- R8: A control write with bits [4:3]=10 enters stop (status bits [4:3]=10), where xtal_en, tick_en and core_en are low. A wake event moves the block to the ring state (status bits [4:3]=11) with src_ring=1, xtal_en=1, the rate forced to 1x and core_en pulsing every cycle.
- R9: The ring state ends and src_ring falls only after xtal_ready has been high on XTAL_STABLE consecutive edges (default 65536). A low cycle restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock, free-running base rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = control word, 1 = settle count |
| cfg_wdata | input | 8 | Write data |
| pll_lock | input | 1 | Multiplier lock indication |
| xtal_ready | input | 1 | Crystal oscillator ready indication |
| ser_act | input | 1 | Serial-port activity |
| irq_act | input | 1 | Enabled interrupt pending |
| mult_sel | output | 2 | Multiplier select: 00 1x, 01 2x, 10 4x |
| div_sel | output | 1 | Slow rate selected |
| src_ring | output | 1 | Ring oscillator selected as source |
| xtal_en | output | 1 | Crystal oscillator enable |
| tick_en | output | 1 | Time-base clock-enable pulse |
| core_en | output | 1 | Core clock-enable pulse |
| status | output | 8 | [1:0] rate, [2] auto-return, [4:3] power state, [5] pending |

## Verification
The assertions assume that ser_act, irq_act, pll_lock and xtal_ready are already synchronous to clk and change only between edges. They also assume that pll_lock does not fall during the cycle in which a pending rate is applied. The bench drives every input on the falling edge and holds it there. It raises lock only after a pending request has been observed, and it pulses the wake inputs for exactly one cycle. It makes no control write in a cycle that also carries a wake event, because the assertion on refused requests is stated for cycles without wake activity.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  typedef enum logic [1:0] {
    RATE_X1  = 2'b00,
    RATE_X2  = 2'b01,
    RATE_X4  = 2'b10,
    RATE_DIV = 2'b11
  } rate_e;

  typedef enum logic [1:0] {
    PS_RUN  = 2'b00,
    PS_IDLE = 2'b01,
    PS_STOP = 2'b10,
    PS_RING = 2'b11
  } pstate_e;
endpackage

// File: rtl/cpm_lock_qual.sv
module cpm_lock_qual #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock_in,
  input  logic [CW-1:0] settle,
  output logic          lock_ok
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!lock_in)             cnt_d = '0;
    else if (cnt_q == '1)     cnt_d = cnt_q;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign lock_ok = lock_in && (cnt_q >= settle);

  // Qualified lock never survives a lock drop (R2)
  assert_lock_needs_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_in |=> (cnt_q == '0));
endmodule

// File: rtl/cpm_tick_div.sv
module cpm_tick_div #(
  parameter int RATIO = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic slow,
  input  logic hold,
  output logic tick
);
  localparam int W = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [W-1:0] LAST_SLOW = W'(RATIO - 1);

  logic [W-1:0] cnt_q, cnt_d, last;

  assign last = slow ? LAST_SLOW : '0;
  assign tick = !hold && (cnt_q == last);

  always_comb begin
    if (restart)   cnt_d = '0;
    else if (hold) cnt_d = cnt_q;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // A slow-rate pulse is never followed by another at once (R4)
  assert_slow_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && slow && !restart) |=> !tick);
endmodule

// File: rtl/cpm_pwr_seq.sv
module cpm_pwr_seq
  import cpm_pkg::*;
#(
  parameter int XTAL_STABLE = 65536
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    idle_req,
  input  logic    stop_req,
  input  logic    wake,
  input  logic    xtal_ready,
  output pstate_e pst
);
  localparam int XW = $clog2(XTAL_STABLE + 1);
  localparam logic [XW-1:0] XLAST = XW'(XTAL_STABLE - 1);

  pstate_e       pst_q, pst_d;
  logic [XW-1:0] xc_q, xc_d;

  always_comb begin
    pst_d = pst_q;
    xc_d  = '0;
    unique case (pst_q)
      PS_RUN: begin
        if (stop_req)      pst_d = PS_STOP;
        else if (idle_req) pst_d = PS_IDLE;
      end
      PS_IDLE: if (wake) pst_d = PS_RUN;
      PS_STOP: if (wake) pst_d = PS_RING;
      PS_RING: begin
        if (xtal_ready) begin
          if (xc_q == XLAST) pst_d = PS_RUN;
          else               xc_d  = xc_q + 1'b1;
        end
      end
      default: pst_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst_q <= PS_RUN;
      xc_q  <= '0;
    end else begin
      pst_q <= pst_d;
      xc_q  <= xc_d;
    end
  end

  assign pst = pst_q;

  assert_ring_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pst_q == PS_RING && !xtal_ready) |=> (pst_q == PS_RING));
  assert_stop_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pst_q == PS_STOP && wake) |=> (pst_q == PS_RING));
  assert_idle_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pst_q == PS_IDLE && wake) |=> (pst_q == PS_RUN));
endmodule

// File: rtl/cpm_top.sv
module cpm_top
  import cpm_pkg::*;
#(
  parameter int DIV_RATIO   = 1024,
  parameter int XTAL_STABLE = 65536,
  parameter int SETTLE_RST  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       pll_lock,
  input  logic       xtal_ready,
  input  logic       ser_act,
  input  logic       irq_act,
  output logic [1:0] mult_sel,
  output logic       div_sel,
  output logic       src_ring,
  output logic       xtal_en,
  output logic       tick_en,
  output logic       core_en,
  output logic [7:0] status
);
  localparam int SW = 8;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  rate_e         rate_q, rate_d, pend_rate_q, pend_rate_d, req_rate;
  logic          pend_q, pend_d, sb_q, sb_d;
  logic [SW-1:0] settle_q, settle_d;
  logic          ctl_wr, wake, lock_ok, stop_wake, sb_fire;
  pstate_e       pst;

  assign ctl_wr    = cfg_wr && !cfg_addr;
  assign req_rate  = rate_e'(cfg_wdata[1:0]);
  assign wake      = ser_act || irq_act;
  assign stop_wake = (pst == PS_STOP) && wake;
  assign sb_fire   = (rate_q == RATE_DIV) && sb_q && wake;

  always_comb begin
    rate_d      = rate_q;
    pend_d      = pend_q;
    pend_rate_d = pend_rate_q;
    sb_d        = sb_q;
    settle_d    = settle_q;
    if (cfg_wr && cfg_addr) settle_d = cfg_wdata[SW-1:0];
    if (ctl_wr)             sb_d     = cfg_wdata[2];
    if (stop_wake || sb_fire) begin
      rate_d = RATE_X1;
      pend_d = 1'b0;
    end else if (ctl_wr) begin
      if (req_rate == RATE_DIV) begin
        rate_d = RATE_DIV;
        pend_d = 1'b0;
      end else if (rate_q == RATE_DIV) begin
        if (req_rate == RATE_X1) rate_d = RATE_X1;
        pend_d = 1'b0;
      end else if (req_rate != rate_q) begin
        pend_d      = 1'b1;
        pend_rate_d = req_rate;
      end else begin
        pend_d = 1'b0;
      end
    end else if (pend_q && lock_ok) begin
      rate_d = pend_rate_q;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rate_q      <= RATE_X1;
      pend_rate_q <= RATE_X1;
      pend_q      <= 1'b0;
      sb_q        <= 1'b0;
      settle_q    <= SW'(SETTLE_RST);
    end else begin
      rate_q      <= rate_d;
      pend_rate_q <= pend_rate_d;
      pend_q      <= pend_d;
      sb_q        <= sb_d;
      settle_q    <= settle_d;
    end
  end

  cpm_lock_qual #(.CW(SW)) u_lock (
    .clk(clk), .rst_n(rst_sn), .lock_in(pll_lock), .settle(settle_q), .lock_ok(lock_ok)
  );

  cpm_pwr_seq #(.XTAL_STABLE(XTAL_STABLE)) u_seq (
    .clk(clk), .rst_n(rst_sn),
    .idle_req(ctl_wr && cfg_wdata[4:3] == 2'b01),
    .stop_req(ctl_wr && cfg_wdata[4:3] == 2'b10),
    .wake(wake), .xtal_ready(xtal_ready), .pst(pst)
  );

  cpm_tick_div #(.RATIO(DIV_RATIO)) u_div (
    .clk(clk), .rst_n(rst_sn), .restart(rate_d != rate_q),
    .slow(rate_q == RATE_DIV), .hold(pst == PS_STOP), .tick(tick_en)
  );

  assign mult_sel = (rate_q == RATE_DIV) ? 2'b00 : rate_q;
  assign div_sel  = (rate_q == RATE_DIV);
  assign src_ring = (pst == PS_RING);
  assign xtal_en  = (pst != PS_STOP);
  assign core_en  = tick_en && (pst == PS_RUN || pst == PS_RING);
  assign status   = {2'b00, pend_q, pst, sb_q, rate_q};

  assert_lock_gate_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(rate_q) != RATE_DIV && rate_q != RATE_DIV && rate_q != $past(rate_q)
     && $past(pst) != PS_STOP) |-> $past(lock_ok));
  assert_div_refuse_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (rate_q == RATE_DIV && ctl_wr && (cfg_wdata[1:0] == 2'b01 || cfg_wdata[1:0] == 2'b10)
     && !wake) |=> (rate_q == RATE_DIV));
  assert_full_tick_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (rate_q != RATE_DIV && pst != PS_STOP) |-> tick_en);
  assert_switchback_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (rate_q == RATE_DIV && sb_q && wake) |=> (rate_q == RATE_X1));
  assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (pst == PS_STOP) |-> (!tick_en && !core_en));
endmodule

// File: tb/cpm_top_tb.sv
module cpm_top_tb;
  localparam int XT = 32;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr, cfg_addr, pll_lock, xtal_ready, ser_act, irq_act;
  logic [7:0] cfg_wdata;
  logic [1:0] mult_sel;
  logic       div_sel, src_ring, xtal_en, tick_en, core_en;
  logic [7:0] status;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cpm_top #(.DIV_RATIO(1024), .XTAL_STABLE(XT), .SETTLE_RST(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pll_lock(pll_lock), .xtal_ready(xtal_ready), .ser_act(ser_act), .irq_act(irq_act),
    .mult_sel(mult_sel), .div_sel(div_sel), .src_ring(src_ring), .xtal_en(xtal_en),
    .tick_en(tick_en), .core_en(core_en), .status(status)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_wake(input bit use_irq);
    @(negedge clk);
    if (use_irq) irq_act = 1'b1; else ser_act = 1'b1;
    @(negedge clk);
    irq_act = 1'b0; ser_act = 1'b0;
  endtask

  task automatic t_reset;
    check(status == 8'h00, "R1 status", status, 8'h00);
    check(mult_sel == 2'b00 && !div_sel && !src_ring && xtal_en, "R1 selects",
          {mult_sel, div_sel, src_ring, xtal_en}, 5'b00001);
    check(tick_en && core_en, "R5 tick at reset", {tick_en, core_en}, 2'b11);
  endtask

  task automatic t_settle;
    pll_lock = 1'b0;
    wr(1'b1, 8'd10);
    wr(1'b0, 8'h01);
    cycles(30);
    check(status[1:0] == 2'b00 && status[5], "R2 pending held", status, 8'h20);
    check(mult_sel == 2'b00, "R2 mult held", mult_sel, 0);
    pll_lock = 1'b1;
    cycles(5);
    check(status[1:0] == 2'b00, "R2 before settle", status[1:0], 0);
    cycles(10);
    check(status[1:0] == 2'b01 && !status[5], "R2 applied 2x", status, 8'h01);
    check(mult_sel == 2'b01, "R2 mult 2x", mult_sel, 1);
    wr(1'b0, 8'h02);
    cycles(2);
    check(mult_sel == 2'b10, "R2 mult 4x", mult_sel, 2);
    check(tick_en, "R5 tick at 4x", tick_en, 1);
    pll_lock = 1'b0;
    wr(1'b0, 8'h00);
    cycles(40);
    check(status[1:0] == 2'b10, "R2 no lock", status[1:0], 2);
    pll_lock = 1'b1;
    cycles(15);
    check(status[1:0] == 2'b00 && mult_sel == 2'b00, "R2 back 1x", status[1:0], 0);
  endtask

  task automatic count_ticks(input string req);
    int total, early, first;
    total = 0; early = 0; first = -1;
    for (int i = 0; i < 4096; i++) begin
      if (tick_en) begin
        total++;
        if (i < 1023) early++;
        if (first < 0) first = i;
      end
      @(negedge clk);
    end
    check(total == 4, {req, " count"}, total, 4);
    check(early == 0 && first == 1023, {req, " first pulse"}, first, 1023);
  endtask

  task automatic t_div_refuse;
    wr(1'b0, 8'h03);
    check(status[1:0] == 2'b11 && div_sel && mult_sel == 2'b00, "R3 slow set",
          {status[1:0], div_sel}, 3'b111);
    count_ticks("R4 slow");
    wr(1'b0, 8'h01);
    cycles(3);
    check(status[1:0] == 2'b11 && !status[5], "R3 refuse 2x", status, 8'h03);
    wr(1'b0, 8'h02);
    cycles(3);
    check(status[1:0] == 2'b11, "R3 refuse 4x", status[1:0], 3);
    wr(1'b0, 8'h00);
    check(status[1:0] == 2'b00, "R3 1x allowed", status[1:0], 0);
    begin
      int hits = 0;
      for (int i = 0; i < 20; i++) begin
        if (tick_en) hits++;
        @(negedge clk);
      end
      check(hits == 20, "R5 every cycle", hits, 20);
    end
    wr(1'b0, 8'h03);
    cycles(600);
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h03);
    count_ticks("R4 restart");
  endtask

  task automatic t_switchback;
    wr(1'b0, 8'h03);
    pulse_wake(1'b1);
    check(status[1:0] == 2'b11, "R6 disabled stays slow", status[1:0], 3);
    wr(1'b0, 8'h07);
    pulse_wake(1'b0);
    check(status[1:0] == 2'b00 && tick_en, "R6 serial return", status[1:0], 0);
    wr(1'b0, 8'h07);
    pulse_wake(1'b1);
    check(status[1:0] == 2'b00, "R6 irq return", status[1:0], 0);
  endtask

  task automatic t_idle;
    wr(1'b0, 8'h08);
    check(status[4:3] == 2'b01, "R7 idle state", status[4:3], 1);
    check(!core_en && tick_en, "R7 core off tick on", {core_en, tick_en}, 2'b01);
    pulse_wake(1'b1);
    check(status[4:3] == 2'b00 && core_en, "R7 wake run", status[4:3], 0);
  endtask

  task automatic t_stop;
    xtal_ready = 1'b0;
    wr(1'b0, 8'h03);
    wr(1'b0, 8'h13);
    check(status[4:3] == 2'b10, "R8 stop state", status[4:3], 2);
    cycles(3);
    check(!xtal_en && !tick_en && !core_en, "R8 stop quiet",
          {xtal_en, tick_en, core_en}, 0);
    pulse_wake(1'b0);
    check(status[4:3] == 2'b11 && src_ring && xtal_en, "R8 ring source",
          {status[4:3], src_ring, xtal_en}, 4'b1111);
    check(status[1:0] == 2'b00 && core_en && tick_en, "R8 ring full speed",
          {status[1:0], core_en}, 3'b001);
    xtal_ready = 1'b1;
    cycles(20);
    xtal_ready = 1'b0;
    cycles(1);
    check(src_ring, "R9 drop restarts", src_ring, 1);
    xtal_ready = 1'b1;
    cycles(XT - 1);
    check(src_ring && status[4:3] == 2'b11, "R9 still ring", status[4:3], 3);
    cycles(2);
    check(!src_ring && status[4:3] == 2'b00, "R9 crystal back", status[4:3], 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = 1'b0; cfg_wdata = 8'h00;
    pll_lock = 1'b0; xtal_ready = 1'b0; ser_act = 1'b0; irq_act = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    t_reset();
    t_settle();
    t_div_refuse();
    t_switchback();
    t_idle();
    t_stop();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule